// File: doc/BRIEF.md
# Reset Source Collector with Cause Latch

This block merges six reset requests into two active-low reset outputs and records which request started the most recent reset. Three requests are power-class: power not yet stable, core supply brown-out and analog supply brown-out. These arrive as digital flags from analog detectors. Three are user-class: watchdog timeout, a software reset request from the CPU, and an external pin that requests reset while it is driven low.

The full-domain output resets everything, including the real-time clock, the slow oscillator and the watchdog. Only power-class requests drive it. The user-domain output resets the rest of the chip and responds to both classes. A user-class reset therefore leaves the always-on timekeeping and watchdog logic running. Each output is held for a fixed stretch after its request goes away. It is then released on a clock edge.

The cause register is one-hot and software can read it. It changes only when a reset begins while no other request is active, and no user reset clears it.

Top module: `resetHub`

## Requirements
- R1: While the power-stable flag is low, both reset outputs are low and the cause register reads 6'b000001.
- R2: After the last power-class request is removed, both outputs rise together on the 16th rising clock edge that follows the removal.
- R3: A core or analog brown-out flag drives both outputs low at once, with no clock edge needed.
- R4: A watchdog or software request drives the user output low from the first clock edge that samples it high. The full output stays high.
- R5: After a user-class request ends, the user output rises on the 16th rising edge after the last edge that sampled the request active.
- R6: The external pin requests reset at a low level and is seen through a two-flop synchronizer. The user output falls on the third edge after the pin goes low and rises on the 18th edge after the pin returns high.
- R7: Cause bit positions: bit0 power-on, bit1 core brown-out, bit2 analog brown-out, bit3 external pin, bit4 watchdog, bit5 software. Exactly one bit is set.
- R8: The cause register is loaded only when a new reset begins. No user reset clears it, so it keeps its value after the reset releases.
- R9: When several requests begin in the same cycle, the lowest bit position wins, so power-class causes beat user-class causes.
- R10: A request that appears while another request is still active does not change the cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running system clock |
| pwrStable | input | 1 | High once the supply is stable; low means power-on reset |
| coreBrownOut | input | 1 | Core supply brown-out flag, active high |
| anaBrownOut | input | 1 | Analog supply brown-out flag, active high |
| wdtTimeout | input | 1 | Watchdog timeout request, synchronous, active high |
| swResetReq | input | 1 | CPU software reset request, synchronous, active high |
| extResetN | input | 1 | External reset pin; low requests reset |
| fullRstN | output | 1 | Full-domain reset, active low |
| userRstN | output | 1 | User-domain reset, active low |
| resetCause | output | 6 | One-hot cause of the most recent reset |

## Verification
The bench counts edges exactly around every release. It checks that each output is still low one edge before the 16th edge and high on it, so a stretch that is one cycle short or long is caught. It also applies requests that start together: watchdog with software, and core brown-out with watchdog. A priority encoder with the wrong sense would latch the wrong bit in those cases. Overlapping requests and a brown-out that outlasts power-on probe R10: a design that reloads the cause on every request edge would overwrite the first cause. Brown-out assertion is checked before any clock edge has passed, and watchdog and software resets are checked to leave the full output high. This exposes a design that makes assertion synchronous or that routes user causes to the full domain.

// File: rtl/resetHubPkg.sv
`timescale 1ns/1ps
package resetHubPkg;
  localparam int NUM_SRC = 6;

  // bit positions of the cause register; lower index wins
  localparam int SRC_POR     = 0;
  localparam int SRC_CORE_BO = 1;
  localparam int SRC_ANA_BO  = 2;
  localparam int SRC_EXT     = 3;
  localparam int SRC_WDT     = 4;
  localparam int SRC_SW      = 5;

  // preset of each source pipeline during power-on: the external pipe
  // starts inactive so it cannot stretch the first user release
  localparam logic [NUM_SRC-1:0] PIPE_PRESET = 6'b110111;

  typedef struct packed {
    logic               capture;   // a new reset begins this cycle
    logic [NUM_SRC-1:0] pick;      // winning cause, one-hot
    logic               userHold;  // a user-class request is active
  } ctrlStrobe_t;
endpackage

// File: rtl/resetHubStretch.sv
`timescale 1ns/1ps
module resetHubStretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic asyncHold,
  input  logic syncHold,
  output logic rstN
);
  localparam int CW = (STRETCH > 2) ? $clog2(STRETCH) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge asyncHold) begin
    if (asyncHold) begin
      cnt  <= '0;
      rstN <= 1'b0;
    end else if (syncHold) begin
      cnt  <= '0;
      rstN <= 1'b0;
    end else if (!rstN) begin
      if (cnt == LAST) rstN <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  // R4
  hold_gives_reset_chk: assert property (@(posedge clk) disable iff (asyncHold)
    syncHold |=> !rstN);
endmodule

// File: rtl/resetHubCtrl.sv
`timescale 1ns/1ps
module resetHubCtrl
  import resetHubPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        pwrStable,
  input  logic        coreBrownOut,
  input  logic        anaBrownOut,
  input  logic        wdtTimeout,
  input  logic        swResetReq,
  input  logic        extResetN,
  output logic        porHold,
  output logic        pwrHoldAsync,
  output ctrlStrobe_t strobe
);
  logic [NUM_SRC-1:0] srcRaw;
  logic [NUM_SRC-1:0] srcSeen;
  logic               anyNow;
  logic               anyPrev;

  assign porHold      = !pwrStable;
  assign pwrHoldAsync = porHold | coreBrownOut | anaBrownOut;

  always_comb begin
    srcRaw              = '0;
    srcRaw[SRC_POR]     = porHold;
    srcRaw[SRC_CORE_BO] = coreBrownOut;
    srcRaw[SRC_ANA_BO]  = anaBrownOut;
    srcRaw[SRC_EXT]     = !extResetN;
    srcRaw[SRC_WDT]     = wdtTimeout;
    srcRaw[SRC_SW]      = swResetReq;
  end

  // equal-depth pipes keep all sources aligned for cause capture;
  // the external one doubles as the pin synchronizer
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrcPipe
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or posedge porHold) begin
      if (porHold) stage <= {SYNC_STAGES{PIPE_PRESET[i]}};
      else         stage <= {stage[SYNC_STAGES-2:0], srcRaw[i]};
    end
    assign srcSeen[i] = stage[SYNC_STAGES-1];
  end

  assign anyNow = |srcSeen;

  always_ff @(posedge clk or posedge porHold) begin
    if (porHold) anyPrev <= 1'b1;
    else         anyPrev <= anyNow;
  end

  always_comb begin
    strobe.capture  = anyNow & !anyPrev;
    strobe.pick     = srcSeen & (~srcSeen + NUM_SRC'(1));
    strobe.userHold = srcSeen[SRC_EXT] | wdtTimeout | swResetReq;
  end

  // R9
  pick_single_chk: assert property (@(posedge clk) disable iff (porHold)
    strobe.capture |-> $onehot(strobe.pick));
endmodule

// File: rtl/resetHubDatapath.sv
`timescale 1ns/1ps
module resetHubDatapath
  import resetHubPkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic               clk,
  input  logic               porHold,
  input  logic               pwrHoldAsync,
  input  ctrlStrobe_t        strobe,
  output logic               fullRstN,
  output logic               userRstN,
  output logic [NUM_SRC-1:0] resetCause
);
  localparam int NUM_DOM = 2;  // 0: full domain, 1: user domain

  logic [NUM_DOM-1:0] domHold;
  logic [NUM_DOM-1:0] domRstN;

  assign domHold[0] = 1'b0;
  assign domHold[1] = strobe.userHold;

  for (genvar d = 0; d < NUM_DOM; d++) begin : gDomain
    resetHubStretch #(.STRETCH(STRETCH)) uStretch (
      .clk      (clk),
      .asyncHold(pwrHoldAsync),
      .syncHold (domHold[d]),
      .rstN     (domRstN[d])
    );
  end

  assign fullRstN = domRstN[0];
  assign userRstN = domRstN[1];

  always_ff @(posedge clk or posedge porHold) begin
    if (porHold)             resetCause <= NUM_SRC'(1) << SRC_POR;
    else if (strobe.capture) resetCause <= strobe.pick;
  end

  // R7
  cause_onehot_chk: assert property (@(posedge clk) disable iff (porHold)
    $onehot(resetCause));
  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (porHold)
    !strobe.capture |=> $stable(resetCause));
endmodule

// File: rtl/resetHub.sv
`timescale 1ns/1ps
module resetHub
  import resetHubPkg::*;
#(
  parameter int STRETCH_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                   clk,
  input  logic                   pwrStable,
  input  logic                   coreBrownOut,
  input  logic                   anaBrownOut,
  input  logic                   wdtTimeout,
  input  logic                   swResetReq,
  input  logic                   extResetN,
  output logic                   fullRstN,
  output logic                   userRstN,
  output logic [NUM_SRC-1:0]     resetCause
);
  logic        porHold;
  logic        pwrHoldAsync;
  ctrlStrobe_t strobe;

  resetHubCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk         (clk),
    .pwrStable   (pwrStable),
    .coreBrownOut(coreBrownOut),
    .anaBrownOut (anaBrownOut),
    .wdtTimeout  (wdtTimeout),
    .swResetReq  (swResetReq),
    .extResetN   (extResetN),
    .porHold     (porHold),
    .pwrHoldAsync(pwrHoldAsync),
    .strobe      (strobe)
  );

  resetHubDatapath #(.STRETCH(STRETCH_CYCLES)) uData (
    .clk         (clk),
    .porHold     (porHold),
    .pwrHoldAsync(pwrHoldAsync),
    .strobe      (strobe),
    .fullRstN    (fullRstN),
    .userRstN    (userRstN),
    .resetCause  (resetCause)
  );

  // R2
  user_covers_full_chk: assert property (@(posedge clk) disable iff (porHold)
    !fullRstN |-> !userRstN);
  // R3
  brownout_full_chk: assert property (@(posedge clk) disable iff (porHold)
    (coreBrownOut || anaBrownOut) |-> !fullRstN);
endmodule

// File: tb/tb_resetHub.sv
`timescale 1ns/1ps
module tb_resetHub;
  logic       clk = 1'b0;
  logic       pwrStable, coreBrownOut, anaBrownOut;
  logic       wdtTimeout, swResetReq, extResetN;
  logic       fullRstN, userRstN;
  logic [5:0] resetCause;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  resetHub dut (
    .clk(clk), .pwrStable(pwrStable), .coreBrownOut(coreBrownOut),
    .anaBrownOut(anaBrownOut), .wdtTimeout(wdtTimeout),
    .swResetReq(swResetReq), .extResetN(extResetN),
    .fullRstN(fullRstN), .userRstN(userRstN), .resetCause(resetCause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testPowerOn();
    edges(3);
    chk("R1 full low in por", fullRstN, 0);
    chk("R1 user low in por", userRstN, 0);
    chk("R1 cause por", resetCause, 6'h01);
    pwrStable = 1'b1;
    edges(15);
    chk("R2 full low at edge 15", fullRstN, 0);
    chk("R2 user low at edge 15", userRstN, 0);
    edges(1);
    chk("R2 full high at edge 16", fullRstN, 1);
    chk("R2 user high at edge 16", userRstN, 1);
    chk("R8 cause kept after por", resetCause, 6'h01);
  endtask

  task automatic testBrownOut(input bit analog);
    if (analog) anaBrownOut = 1'b1; else coreBrownOut = 1'b1;
    #1;
    chk("R3 full low without edge", fullRstN, 0);
    chk("R3 user low without edge", userRstN, 0);
    edges(3);
    anaBrownOut = 1'b0;
    coreBrownOut = 1'b0;
    edges(15);
    chk("R2 full low after brownout", fullRstN, 0);
    edges(1);
    chk("R2 full high after brownout", fullRstN, 1);
    chk("R2 user high after brownout", userRstN, 1);
    chk("R7 brownout cause", resetCause, analog ? 6'h04 : 6'h02);
  endtask

  task automatic testWatchdog();
    wdtTimeout = 1'b1;
    edges(1);
    chk("R4 wdt user low", userRstN, 0);
    chk("R4 wdt full high", fullRstN, 1);
    wdtTimeout = 1'b0;
    edges(15);
    chk("R5 wdt user low at edge 15", userRstN, 0);
    edges(1);
    chk("R5 wdt user high at edge 16", userRstN, 1);
    chk("R7 wdt cause", resetCause, 6'h10);
  endtask

  task automatic testSoftware();
    swResetReq = 1'b1;
    edges(3);
    chk("R4 sw user low", userRstN, 0);
    chk("R4 sw full high", fullRstN, 1);
    swResetReq = 1'b0;
    edges(15);
    chk("R5 sw user low at edge 15", userRstN, 0);
    edges(1);
    chk("R5 sw user high", userRstN, 1);
    chk("R7 sw cause", resetCause, 6'h20);
  endtask

  task automatic testExternal();
    extResetN = 1'b0;
    edges(2);
    chk("R6 ext not yet seen", userRstN, 1);
    edges(1);
    chk("R6 ext user low at edge 3", userRstN, 0);
    edges(2);
    extResetN = 1'b1;
    edges(17);
    chk("R6 ext user low at edge 17", userRstN, 0);
    edges(1);
    chk("R6 ext user high at edge 18", userRstN, 1);
    chk("R6 ext full untouched", fullRstN, 1);
    chk("R7 ext cause", resetCause, 6'h08);
  endtask

  task automatic testPriority();
    wdtTimeout = 1'b1;
    swResetReq = 1'b1;
    edges(1);
    wdtTimeout = 1'b0;
    swResetReq = 1'b0;
    edges(16);
    chk("R9 wdt beats sw", resetCause, 6'h10);
    coreBrownOut = 1'b1;
    wdtTimeout = 1'b1;
    edges(1);
    coreBrownOut = 1'b0;
    wdtTimeout = 1'b0;
    edges(16);
    chk("R9 brownout beats wdt", resetCause, 6'h02);
    chk("R9 full released", fullRstN, 1);
    chk("R9 user released", userRstN, 1);
  endtask

  task automatic testNoRestart();
    wdtTimeout = 1'b1;
    edges(4);
    swResetReq = 1'b1;
    edges(4);
    wdtTimeout = 1'b0;
    swResetReq = 1'b0;
    edges(16);
    chk("R10 overlap keeps wdt", resetCause, 6'h10);
    chk("R10 user released", userRstN, 1);
    pwrStable = 1'b0;
    coreBrownOut = 1'b1;
    edges(3);
    pwrStable = 1'b1;
    edges(5);
    chk("R10 brownout under por keeps por", resetCause, 6'h01);
    coreBrownOut = 1'b0;
    edges(16);
    chk("R10 full released after tail", fullRstN, 1);
    chk("R10 cause still por", resetCause, 6'h01);
  endtask

  initial begin
    pwrStable = 1'b0; coreBrownOut = 1'b0; anaBrownOut = 1'b0;
    wdtTimeout = 1'b0; swResetReq = 1'b0; extResetN = 1'b1;
    #1;
    testPowerOn();
    testBrownOut(1'b0);
    testBrownOut(1'b1);
    testWatchdog();
    testSoftware();
    testExternal();
    testPriority();
    testNoRestart();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule